// File: doc/BRIEF.md
# Error-Corrected Word Memory with Sub-Word Write Merging

This block is an on-chip static memory that keeps each 64-bit data word together with an 8-bit single-error-correcting, double-error-detecting check code. A requester drives a single-beat request: a word address, a write flag, eight byte lanes and 64 bits of write data. Reads come back one cycle after the request is accepted. The data is corrected when a single bit has flipped, and is returned as stored when two bits have flipped.

A write that enables all eight byte lanes stores the data and a freshly computed code in one array cycle. A write that enables fewer lanes reads the old word first. That read is checked and corrected, the enabled lanes are merged into it, and the result is written back with a new code. This takes a second array cycle, and `ready` is low during it. If the read phase of such a write finds an uncorrectable word, the write-back is cancelled. Because of this, a word that never had a full write, or that has been damaged, can raise an error event on a write access as well as on a read.

Every detected error is reported as a one-cycle pulse on a sideband interface meant for an external monitor. The block raises no interrupt or transfer request of its own. The array depth is a parameter: 10240 words gives 80 KB, and the default is smaller. A test-only injection input flips chosen stored bits during array writes.

Top module: `ecc_sram`

## Requirements
- R1: A write with `req_be` = 8'hFF stores the data and a new check code without reading the array, and `ready` stays high in the following cycle. A later read returns exactly that data with no error event.
- R2: A read accepted in cycle t (`req_valid` and `ready` high) gives `rsp_valid` high in cycle t+1, with the word's data on `rsp_rdata`. Reads may be accepted back to back.
- R3: A write with any other `req_be` value replaces only the byte lanes whose enable bit is set, where bit i selects data bits 8i+7..8i. The other lanes keep the old word's corrected contents.
- R4: A sub-word write accepted in cycle t holds `ready` low in cycle t+1 only, and `ready` is high again in cycle t+2.
- R5: A single flipped data bit is corrected on read. The error report pulses with `err_uncorr` = 0.
- R6: A single flipped check bit leaves the read data intact and is reported as correctable.
- R7: Two flipped bits in one word are reported with `err_uncorr` = 1, and the read returns the stored data without correction.
- R8: If the read phase of a sub-word write finds an uncorrectable word, the word is left unchanged and the error is reported with that word's address.
- R9: If the read phase of a sub-word write finds a correctable word, the corrected and merged word is written back, so a later read shows the merged value with no error event.
- R10: The error report is valid for one cycle, in the same cycle as the response, and carries the word address. `err_syndrome` bits 6..0 give the codeword position of the flipped bit, and bit 7 is the overall parity mismatch. Data bits 0..63 occupy, in ascending order, the positions from 3 to 71 that are not powers of two. Check bit j (j < 7) sits at position 2^j, and check bit 7 is the overall parity.
- R11: While reset is asserted, and after it, `ready` is high and `rsp_valid` and `err_valid` are low.
- R12: When `inj_en` is high during an array write, the stored 72-bit word is XORed with `inj_mask`. Bits 63..0 of the mask hit data bits, and bits 71..64 hit check bits 7..0. A later write without injection stores a clean word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_be | input | 8 | Byte-lane enables for writes |
| req_wdata | input | 64 | Write data |
| ready | output | 1 | Low while a sub-word write occupies the array |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data, corrected where possible |
| err_valid | output | 1 | One-cycle error event |
| err_uncorr | output | 1 | 1 = uncorrectable, 0 = corrected |
| err_addr | output | AW | Word address of the error event |
| err_syndrome | output | 8 | {overall parity mismatch, 7-bit position syndrome} |
| inj_en | input | 1 | Test only: apply the injection mask on array writes |
| inj_mask | input | 72 | Test only: {check[7:0], data[63:0]} bits to flip |

## Verification
The embedded properties watch the cycle-level protocol on every clock. A stall lasts exactly one cycle and only follows an accepted sub-word write. A full write never stalls. Responses appear only one cycle after an accepted read, and every error pulse carries the address of the access that was accepted one cycle earlier. Data correctness needs the bench's directed scenarios: the byte merge, correction of data and check bits, raw return for double errors, cancellation of the write-back on an uncorrectable read phase, and the syndrome values, all checked against injected faults.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;
  localparam int DW = 64;
  localparam int CW = 8;
  localparam int WW = DW + CW;
  localparam int NB = DW / 8;

  // Codeword position (3..71, skipping powers of two) of data bit k.
  function automatic int data_pos(input int k);
    int n;
    int res;
    n   = 0;
    res = 0;
    for (int p = 3; p < 72; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == k) res = p;
        n++;
      end
    end
    return res;
  endfunction

  function automatic logic [CW-1:0] make_check(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    int pos;
    c = '0;
    for (int k = 0; k < DW; k++) begin
      pos = data_pos(k);
      for (int j = 0; j < 7; j++)
        if (pos[j]) c[j] = c[j] ^ d[k];
    end
    c[7] = (^d) ^ (^c[6:0]);
    return c;
  endfunction
endpackage

// File: rtl/ecc_sram_enc.sv
module ecc_sram_enc
  import ecc_sram_pkg::*;
(
  input  logic [DW-1:0] data,
  output logic [CW-1:0] check
);
  always_comb check = make_check(data);
endmodule

// File: rtl/ecc_sram_dec.sv
module ecc_sram_dec
  import ecc_sram_pkg::*;
(
  input  logic [DW-1:0] data,
  input  logic [CW-1:0] check,
  output logic [DW-1:0] fixed,
  output logic          corr,
  output logic          uncorr,
  output logic [CW-1:0] syndrome
);
  logic [CW-1:0] recomputed;
  logic [6:0]    pos_syn;
  logic          par_bad;
  logic          out_range;
  logic [DW-1:0] flip;

  always_comb begin
    recomputed = make_check(data);
    pos_syn    = recomputed[6:0] ^ check[6:0];
    par_bad    = ^{data, check};
    out_range  = (pos_syn > 7'd71);
    corr       = par_bad && !out_range;
    uncorr     = (!par_bad && (pos_syn != 7'd0)) || (par_bad && out_range);
    syndrome   = {par_bad, pos_syn};
  end

  for (genvar k = 0; k < DW; k++) begin : g_flip
    localparam int P = data_pos(k);
    assign flip[k] = corr && (pos_syn == 7'(P));
  end

  assign fixed = data ^ flip;
endmodule

// File: rtl/ecc_sram_mem.sv
module ecc_sram_mem #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 72,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) cells[addr] <= wdata;
      else    rdata       <= cells[addr];
    end
  end
endmodule

// File: rtl/ecc_sram.sv
module ecc_sram
  import ecc_sram_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [NB-1:0] req_be,
  input  logic [DW-1:0] req_wdata,
  output logic          ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          err_valid,
  output logic          err_uncorr,
  output logic [AW-1:0] err_addr,
  output logic [CW-1:0] err_syndrome,
  input  logic          inj_en,
  input  logic [WW-1:0] inj_mask
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q_n  <= rst_meta;
    end
  end

  // stage holding the access whose array read is in flight
  logic          st_vld, st_rmw, st_vld_d, st_rmw_d;
  logic [AW-1:0] st_addr, st_addr_d;
  logic [NB-1:0] st_be, st_be_d;
  logic [DW-1:0] st_wdata, st_wdata_d;
  logic          accept, full_wr, st_en;

  always_comb begin
    accept     = req_valid && ready;
    full_wr    = req_we && (&req_be);
    st_en      = accept;
    st_vld_d   = accept && !full_wr;
    st_rmw_d   = accept && req_we;
    st_addr_d  = req_addr;
    st_be_d    = req_be;
    st_wdata_d = req_wdata;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st_vld   <= 1'b0;
      st_rmw   <= 1'b0;
      st_addr  <= '0;
      st_be    <= '0;
      st_wdata <= '0;
    end else begin
      st_vld <= st_vld_d;
      st_rmw <= st_rmw_d;
      if (st_en) begin
        st_addr  <= st_addr_d;
        st_be    <= st_be_d;
        st_wdata <= st_wdata_d;
      end
    end
  end

  // array, check on read, merge and code on write
  logic [WW-1:0] arr_q, arr_d;
  logic          arr_en, arr_we, wb;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] fixed, merged, wr_data;
  logic [CW-1:0] wr_check, syn;
  logic          dec_corr, dec_uncorr;

  ecc_sram_dec u_dec (
    .data(arr_q[DW-1:0]), .check(arr_q[WW-1:DW]), .fixed(fixed),
    .corr(dec_corr), .uncorr(dec_uncorr), .syndrome(syn)
  );

  for (genvar i = 0; i < NB; i++) begin : g_merge
    assign merged[8*i +: 8] = st_be[i] ? st_wdata[8*i +: 8] : fixed[8*i +: 8];
  end

  always_comb begin
    wb       = st_vld && st_rmw && !dec_uncorr;
    arr_en   = accept || wb;
    arr_we   = wb || (accept && full_wr);
    arr_addr = wb ? st_addr : req_addr;
    wr_data  = wb ? merged : req_wdata;
  end

  ecc_sram_enc u_enc (.data(wr_data), .check(wr_check));

  always_comb arr_d = {wr_check, wr_data} ^ (inj_en ? inj_mask : '0);

  ecc_sram_mem #(.DEPTH(DEPTH), .WIDTH(WW)) u_mem (
    .clk(clk), .en(arr_en), .we(arr_we), .addr(arr_addr),
    .wdata(arr_d), .rdata(arr_q)
  );

  always_comb begin
    ready        = !(st_vld && st_rmw);
    rsp_valid    = st_vld && !st_rmw;
    rsp_rdata    = fixed;
    err_valid    = st_vld && (dec_corr || dec_uncorr);
    err_uncorr   = dec_uncorr;
    err_addr     = st_addr;
    err_syndrome = syn;
  end

  // R4
  stall_one_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ready |=> ready);
  // R4
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ready |-> $past(req_valid && req_we && !(&req_be)));
  // R1
  full_nostall_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && ready && req_we && (&req_be)) |=> ready);
  // R2
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    rsp_valid |-> $past(req_valid && ready && !req_we));
  // R10
  err_addr_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    err_valid |-> (err_addr == $past(req_addr)));
endmodule

// File: tb/tb_ecc_sram.sv
module tb_ecc_sram;
  localparam int AW = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_we;
  logic [AW-1:0] req_addr;
  logic [7:0]  req_be;
  logic [63:0] req_wdata;
  logic        ready, rsp_valid, err_valid, err_uncorr;
  logic [63:0] rsp_rdata;
  logic [AW-1:0] err_addr;
  logic [7:0]  err_syndrome;
  logic        inj_en;
  logic [71:0] inj_mask;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ecc_sram dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .ready(ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .err_valid(err_valid), .err_uncorr(err_uncorr), .err_addr(err_addr),
    .err_syndrome(err_syndrome), .inj_en(inj_en), .inj_mask(inj_mask)
  );

  function automatic logic [6:0] bit_pos(input int k);
    int seen = 0;
    logic [6:0] r = '0;
    for (int p = 1; p <= 71; p++) begin
      if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32 && p != 64) begin
        if (seen == k) r = 7'(p);
        seen++;
      end
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0; req_we = 1'b0; req_be = '0; req_addr = '0;
    req_wdata = '0; inj_en = 1'b0; inj_mask = '0;
  endtask

  task automatic wr_full(input logic [AW-1:0] a, input logic [63:0] d, input logic [71:0] m);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_be = 8'hFF; req_addr = a; req_wdata = d;
    inj_en = (m != '0); inj_mask = m;
    @(negedge clk);
    idle();
    chk(ready == 1'b1, "R1 no stall on full write", 72'(ready), 72'd1);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [63:0] d, output logic v,
                    output logic ev, output logic eu, output logic [AW-1:0] ea,
                    output logic [7:0] es);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(negedge clk);
    idle();
    d = rsp_rdata; v = rsp_valid; ev = err_valid; eu = err_uncorr; ea = err_addr; es = err_syndrome;
    @(posedge clk);
    #1;
    chk(err_valid == 1'b0, "R10 error pulse lasts one cycle", 72'(err_valid), 72'd0);
  endtask

  task automatic wr_part(input logic [AW-1:0] a, input logic [7:0] be, input logic [63:0] d,
                         output logic ev, output logic eu, output logic [AW-1:0] ea);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_be = be; req_addr = a; req_wdata = d;
    @(negedge clk);
    idle();
    chk(ready == 1'b0, "R4 stall cycle after sub-word write", 72'(ready), 72'd0);
    ev = err_valid; eu = err_uncorr; ea = err_addr;
    @(negedge clk);
    chk(ready == 1'b1, "R4 ready back after one cycle", 72'(ready), 72'd1);
  endtask

  task automatic t_reset();
    chk(ready == 1'b1, "R11 ready in reset", 72'(ready), 72'd1);
    chk(rsp_valid == 1'b0, "R11 rsp_valid in reset", 72'(rsp_valid), 72'd0);
    chk(err_valid == 1'b0, "R11 err_valid in reset", 72'(err_valid), 72'd0);
  endtask

  task automatic t_full_rw();
    logic [63:0] d; logic v, ev, eu; logic [AW-1:0] ea; logic [7:0] es;
    wr_full(10'd5, 64'hDEAD_BEEF_0123_4567, '0);
    wr_full(10'd1023, 64'hFFFF_0000_A5A5_5A5A, '0);
    rd(10'd5, d, v, ev, eu, ea, es);
    chk(v == 1'b1, "R2 rsp_valid one cycle after read", 72'(v), 72'd1);
    chk(d == 64'hDEAD_BEEF_0123_4567, "R1 full write data", 72'(d), 72'hDEAD_BEEF_0123_4567);
    chk(ev == 1'b0, "R1 no error on clean word", 72'(ev), 72'd0);
    rd(10'd1023, d, v, ev, eu, ea, es);
    chk(d == 64'hFFFF_0000_A5A5_5A5A, "R2 read last address", 72'(d), 72'hFFFF_0000_A5A5_5A5A);
    // R2 back-to-back reads
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 10'd5;
    @(negedge clk);
    req_addr = 10'd1023;
    chk(rsp_valid && rsp_rdata == 64'hDEAD_BEEF_0123_4567, "R2 back-to-back first",
        72'(rsp_rdata), 72'hDEAD_BEEF_0123_4567);
    @(negedge clk);
    idle();
    chk(rsp_valid && rsp_rdata == 64'hFFFF_0000_A5A5_5A5A, "R2 back-to-back second",
        72'(rsp_rdata), 72'hFFFF_0000_A5A5_5A5A);
  endtask

  task automatic t_partial();
    logic [63:0] d; logic v, ev, eu; logic [AW-1:0] ea; logic [7:0] es;
    wr_full(10'd9, 64'h1111_1111_1111_1111, '0);
    wr_part(10'd9, 8'h0F, 64'hAAAA_AAAA_AAAA_AAAA, ev, eu, ea);
    chk(ev == 1'b0, "R3 clean RMW no error", 72'(ev), 72'd0);
    rd(10'd9, d, v, ev, eu, ea, es);
    chk(d == 64'h1111_1111_AAAA_AAAA, "R3 low lanes merged", 72'(d), 72'h1111_1111_AAAA_AAAA);
    wr_part(10'd9, 8'h81, 64'h2200_0000_0000_0033, ev, eu, ea);
    rd(10'd9, d, v, ev, eu, ea, es);
    chk(d == 64'h2211_1111_AAAA_AA33, "R3 edge lanes merged", 72'(d), 72'h2211_1111_AAAA_AA33);
  endtask

  task automatic t_single();
    logic [63:0] d; logic v, ev, eu; logic [AW-1:0] ea; logic [7:0] es;
    wr_full(10'd20, 64'h0F0F_F0F0_1234_5678, 72'(1) << 10);
    rd(10'd20, d, v, ev, eu, ea, es);
    chk(d == 64'h0F0F_F0F0_1234_5678, "R5 data bit corrected", 72'(d), 72'h0F0F_F0F0_1234_5678);
    chk(ev && !eu, "R5 correctable report", 72'({ev, eu}), 72'b10);
    chk(ea == 10'd20, "R10 error address", 72'(ea), 72'd20);
    chk(es == {1'b1, bit_pos(10)}, "R10 syndrome for data bit 10", 72'(es), 72'({1'b1, bit_pos(10)}));
    wr_full(10'd21, 64'h0000_0000_0000_00C3, 72'(1) << 67);
    rd(10'd21, d, v, ev, eu, ea, es);
    chk(d == 64'hC3, "R6 data intact with check bit flip", 72'(d), 72'hC3);
    chk(ev && !eu, "R6 correctable report", 72'({ev, eu}), 72'b10);
    chk(es == 8'h88, "R6 syndrome for check bit 3", 72'(es), 72'h88);
  endtask

  task automatic t_double();
    logic [63:0] d; logic v, ev, eu; logic [AW-1:0] ea; logic [7:0] es;
    wr_full(10'd30, 64'h5555_0000_FFFF_0000, 72'h3);
    rd(10'd30, d, v, ev, eu, ea, es);
    chk(ev && eu, "R7 uncorrectable report", 72'({ev, eu}), 72'b11);
    chk(d == 64'h5555_0000_FFFF_0003, "R7 raw data returned", 72'(d), 72'h5555_0000_FFFF_0003);
  endtask

  task automatic t_rmw_err();
    logic [63:0] d; logic v, ev, eu; logic [AW-1:0] ea; logic [7:0] es;
    wr_full(10'd40, 64'h0123_4567_89AB_CDEF, 72'h30);
    wr_part(10'd40, 8'h01, 64'h0000_0000_0000_0099, ev, eu, ea);
    chk(ev && eu, "R8 RMW uncorrectable reported", 72'({ev, eu}), 72'b11);
    chk(ea == 10'd40, "R8 RMW error address", 72'(ea), 72'd40);
    rd(10'd40, d, v, ev, eu, ea, es);
    chk(ev && eu && d == 64'h0123_4567_89AB_CDDF, "R8 word unchanged after aborted RMW",
        72'(d), 72'h0123_4567_89AB_CDDF);
    wr_full(10'd41, 64'hCAFE_F00D_0000_1111, 72'(1) << 40);
    wr_part(10'd41, 8'hF0, 64'h7777_7777_0000_0000, ev, eu, ea);
    chk(ev && !eu, "R9 RMW correctable reported", 72'({ev, eu}), 72'b10);
    rd(10'd41, d, v, ev, eu, ea, es);
    chk(d == 64'h7777_7777_0000_1111, "R9 merged corrected word", 72'(d), 72'h7777_7777_0000_1111);
    chk(ev == 1'b0, "R9 word clean after write-back", 72'(ev), 72'd0);
  endtask

  task automatic t_inject_clear();
    logic [63:0] d; logic v, ev, eu; logic [AW-1:0] ea; logic [7:0] es;
    wr_full(10'd50, 64'h1, 72'(1) << 71);
    rd(10'd50, d, v, ev, eu, ea, es);
    chk(ev && !eu && es == 8'h80, "R12 overall parity bit flipped", 72'(es), 72'h80);
    wr_full(10'd50, 64'h2, '0);
    rd(10'd50, d, v, ev, eu, ea, es);
    chk(!ev && d == 64'h2, "R12 clean after plain write", 72'(d), 72'h2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_full_rw();
    t_partial();
    t_single();
    t_double();
    t_rmw_err();
    t_inject_clear();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule